// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-rank, four-bank SDR SDRAM between reset and the moment the memory may be used. Once reset is released it keeps clock enable and the data masks high. It sends only NOP commands until a settle interval has elapsed. The interval is given in microseconds and converted to cycles from a clock-frequency parameter. After that it issues one precharge of all banks, then a group of auto-refresh commands and a mode register load. A parameter chooses which of those two steps comes first. Fixed NOP gaps follow each command. When the last gap has elapsed, `init_done` goes high.

The mode word comes from four configuration inputs: burst length code, interleaved burst order, CAS latency code, and a flag that selects burst reads with single-location writes. The inputs are sampled in the cycle the mode load is issued. Reserved address and bank bits are driven low. A CAS latency code other than 2 or 3 is replaced by latency 2. A burst length code that is reserved, or full page requested together with interleaved order, is replaced by length 1. In either case a sticky `config_error` flag is raised.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is high, and in every cycle after it, `sd_cke` and every `sd_dqm` bit are 1. Reset drives the command pins to NOP ({cs_n,ras_n,cas_n,we_n} = 0111) and clears `init_done` and `config_error`.
- R2: After the first clock edge at which reset is sampled low, output cycles 0 to SETTLE_US*CLK_MHZ-1 are NOP. The precharge command appears in cycle SETTLE_US*CLK_MHZ.
- R3: The first non-NOP command is precharge-all: command 0010, address bit 10 set, all other address bits 0, bank address 0.
- R4: Auto-refresh (command 0001, address and bank 0) is issued REFRESH_COUNT times. Values below 2 are raised to 2.
- R5: The next command follows T_RP cycles after a precharge, T_RFC cycles after a refresh and T_MRD cycles after a mode load. Every cycle in between is NOP.
- R6: The mode load (command 0000) follows the last refresh when MRS_FIRST is 0. When MRS_FIRST is 1 it comes between the precharge and the first refresh.
- R7: In the mode load cycle, address bits [2:0] carry the burst length code and bit 3 the burst order (1 = interleaved). Bits [6:4] carry the CAS latency code, bits [8:7] are 00 and bit 9 is the single-write flag. Every address bit above 9 and both bank bits are 0.
- R8: A CAS latency code other than 010 or 011 is sent as 010. A burst length code of 100, 101 or 110, or 111 with interleaved order, is sent as 000. The other fields are sent unchanged.
- R9: `config_error` goes high in the mode load cycle if R8 replaced either field. It then stays high until reset. Otherwise it stays 0.
- R10: `init_done` rises exactly one closing gap after the last command (T_MRD if the mode load is last, otherwise T_RFC). From then until reset it stays high and the command pins stay NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Requested burst length code |
| cfg_interleave | input | 1 | 1 = interleaved burst order |
| cfg_cas_lat | input | 3 | Requested CAS latency code |
| cfg_single_write | input | 1 | 1 = burst reads, single-location writes |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_dqm | output | DQM_W | Data masks, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Row/column address bus, carries the mode word |
| init_done | output | 1 | Sequence complete, sticky until reset |
| config_error | output | 1 | A configuration field was replaced, sticky until reset |

## Verification
The bound checker tests these rules on every cycle. Nothing but NOP may appear inside the settle window, and the first real command must be precharge with bit 10 set. A mode load must carry zero reserved bits and a legal latency code. `config_error` may rise only together with a mode load. `init_done` must stay high, with NOP only, once it has risen. Exact gap lengths, refresh count, step order under each MRS_FIRST setting, and the field replacement for each illegal pattern can be shown only by the bench. Its cycle model runs two differently parameterized instances through legal, full-page and illegal configurations.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command pins packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD_MODE = 4'b0000,
    CMD_AUTO_REF  = 4'b0001,
    CMD_PRE_ALL   = 4'b0010,
    CMD_NOP       = 4'b0111
  } sdram_cmd_e;

  // next step the sequencer issues when its timer expires
  typedef enum logic [2:0] {
    STEP_PRE,
    STEP_REF,
    STEP_MODE,
    STEP_FINISH,
    STEP_IDLE
  } init_step_e;

  localparam int PRE_ALL_BIT = 10;
  localparam logic [2:0] CL_FALLBACK = 3'b010;
  localparam logic [2:0] BL_FALLBACK = 3'b000;

endpackage

// File: rtl/mode_word_encoder.sv
module mode_word_encoder #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        burst_len,
  input  logic              interleave,
  input  logic [2:0]        cas_lat,
  input  logic              single_write,
  output logic [ADDR_W-1:0] word,
  output logic              illegal
);
  import sdram_init_pkg::*;

  logic       cl_ok;
  logic       bl_ok;
  logic [2:0] cl_eff;
  logic [2:0] bl_eff;

  always_comb begin
    cl_ok = (cas_lat == 3'b010) || (cas_lat == 3'b011);
    unique case (burst_len)
      3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
      3'b111:                         bl_ok = !interleave;
      default:                        bl_ok = 1'b0;
    endcase
    cl_eff  = cl_ok ? cas_lat : CL_FALLBACK;
    bl_eff  = bl_ok ? burst_len : BL_FALLBACK;
    illegal = !(cl_ok && bl_ok);
  end

  // low ten bits carry fields; everything above is reserved and zero
  generate
    if (ADDR_W > 10) begin : g_reserved_hi
      assign word[ADDR_W-1:10] = '0;
    end
  endgenerate
  assign word[9:0] = {single_write, 2'b00, cl_eff, interleave, bl_eff};

endmodule

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int          CNT_W     = 8,
  parameter logic [CNT_W-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RESET_VAL;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2,
  parameter int CLK_MHZ       = 100,
  parameter int SETTLE_US     = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 7,
  parameter int T_MRD         = 2,
  parameter bit MRS_FIRST     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_single_write,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              config_error
);
  import sdram_init_pkg::*;

  localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_US < 1) ? 1 : CLK_MHZ * SETTLE_US;
  localparam int REF_N      = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
  localparam int RP_C       = (T_RP  < 1) ? 1 : T_RP;
  localparam int RFC_C      = (T_RFC < 1) ? 1 : T_RFC;
  localparam int MRD_C      = (T_MRD < 1) ? 1 : T_MRD;
  localparam int MAX_GAP    = (RP_C > RFC_C) ? ((RP_C > MRD_C) ? RP_C : MRD_C)
                                             : ((RFC_C > MRD_C) ? RFC_C : MRD_C);
  localparam int MAX_WAIT   = (SETTLE_CYC > MAX_GAP) ? SETTLE_CYC : MAX_GAP;
  localparam int CNT_W      = $clog2(MAX_WAIT + 1);
  localparam int REF_W      = $clog2(REF_N + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] GAP_RP    = CNT_W'(RP_C - 1);
  localparam logic [CNT_W-1:0] GAP_RFC   = CNT_W'(RFC_C - 1);
  localparam logic [CNT_W-1:0] GAP_MRD   = CNT_W'(MRD_C - 1);
  localparam logic [REF_W-1:0] REF_LAST  = REF_W'(REF_N - 1);

  init_step_e        step_q;
  logic [REF_W-1:0]  ref_cnt_q;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              err_q;

  logic              tmr_expired;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_load_val;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_illegal;

  mode_word_encoder #(.ADDR_W(ADDR_W)) i_mode_enc (
    .burst_len    (cfg_burst_len),
    .interleave   (cfg_interleave),
    .cas_lat      (cfg_cas_lat),
    .single_write (cfg_single_write),
    .word         (mode_word),
    .illegal      (mode_illegal)
  );

  init_wait_timer #(.CNT_W(CNT_W), .RESET_VAL(SETTLE_LD)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .expired  (tmr_expired)
  );

  // gap to the next command is loaded as the command is issued
  always_comb begin
    tmr_load = tmr_expired && (step_q != STEP_IDLE);
    unique case (step_q)
      STEP_PRE:  tmr_load_val = GAP_RP;
      STEP_REF:  tmr_load_val = GAP_RFC;
      STEP_MODE: tmr_load_val = GAP_MRD;
      default:   tmr_load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= STEP_PRE;
      ref_cnt_q <= '0;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      if (tmr_expired) begin
        unique case (step_q)
          STEP_PRE: begin
            cmd_q               <= CMD_PRE_ALL;
            addr_q[PRE_ALL_BIT] <= 1'b1;
            step_q              <= MRS_FIRST ? STEP_MODE : STEP_REF;
          end
          STEP_REF: begin
            cmd_q     <= CMD_AUTO_REF;
            ref_cnt_q <= ref_cnt_q + 1'b1;
            if (ref_cnt_q == REF_LAST) begin
              step_q <= MRS_FIRST ? STEP_FINISH : STEP_MODE;
            end
          end
          STEP_MODE: begin
            cmd_q  <= CMD_LOAD_MODE;
            addr_q <= mode_word;
            err_q  <= mode_illegal;
            step_q <= MRS_FIRST ? STEP_REF : STEP_FINISH;
          end
          STEP_FINISH: begin
            done_q <= 1'b1;
            step_q <= STEP_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sd_cke       = 1'b1;
  assign sd_dqm       = '1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba        = '0;
  assign sd_addr      = addr_q;
  assign init_done    = done_q;
  assign config_error = err_q;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int SETTLE_CYC = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done,
  input logic              config_error
);
  localparam int CW = $clog2(SETTLE_CYC + 1) + 1;

  logic [3:0]    cmd;
  logic [CW-1:0] since_rst;
  logic          seen_cmd;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      seen_cmd  <= 1'b0;
    end else begin
      if (since_rst < CW'(SETTLE_CYC)) since_rst <= since_rst + 1'b1;
      if (cmd != 4'b0111) seen_cmd <= 1'b1;
    end
  end

  AST_SETTLE_NOP: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(SETTLE_CYC)) |-> (cmd == 4'b0111)); // R2

  AST_FIRST_IS_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
    (!seen_cmd && cmd != 4'b0111) |-> (cmd == 4'b0010)); // R3

  AST_PRECHARGE_ALL_BIT: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> (sd_addr[10] && sd_ba == '0)); // R3

  AST_MODE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (sd_ba == '0 && sd_addr[8:7] == 2'b00
                          && (sd_addr >> 10) == '0)); // R7

  AST_MODE_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011)); // R8

  AST_ERROR_ONLY_AT_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(config_error) |-> (cmd == 4'b0000)); // R9

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
    config_error |=> config_error); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R10

  AST_DONE_ONLY_NOP: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == 4'b0111)); // R10

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .SETTLE_CYC (SETTLE_CYC)
) i_chk (.*);

// File: tb/test_sdram_powerup_seq.sv
module test_sdram_powerup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int BA_W       = 2;
  localparam int DQM_W      = 2;
  localparam int CLK_MHZ    = 1;
  localparam int SETTLE_US  = 200;
  localparam int SETTLE     = CLK_MHZ * SETTLE_US;
  // instance A: refresh group then mode load
  localparam int NREF_A = 2, RP_A = 2, RFC_A = 6, MRD_A = 2, MF_A = 0;
  // instance B: mode load then refresh group
  localparam int NREF_B = 3, RP_B = 1, RFC_B = 4, MRD_B = 3, MF_B = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_bl = 3'b000;
  logic       cfg_il = 1'b0;
  logic [2:0] cfg_cl = 3'b010;
  logic       cfg_sw = 1'b0;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done, a_err;
  logic [DQM_W-1:0] a_dqm;
  logic [BA_W-1:0]  a_ba;
  logic [ADDR_W-1:0] a_addr;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done, b_err;
  logic [DQM_W-1:0] b_dqm;
  logic [BA_W-1:0]  b_ba;
  logic [ADDR_W-1:0] b_addr;

  int vectors = 0;
  int miscompares = 0;
  int q_a[$];
  int q_b[$];
  int mrs_a, mrs_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_powerup_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .CLK_MHZ(CLK_MHZ),
    .SETTLE_US(SETTLE_US), .REFRESH_COUNT(NREF_A), .T_RP(RP_A),
    .T_RFC(RFC_A), .T_MRD(MRD_A), .MRS_FIRST(MF_A[0])
  ) i_sdram_powerup_seq (
    .clk(clk), .rst(rst), .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_il),
    .cfg_cas_lat(cfg_cl), .cfg_single_write(cfg_sw), .sd_cke(a_cke),
    .sd_dqm(a_dqm), .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas),
    .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr), .init_done(a_done),
    .config_error(a_err)
  );

  sdram_powerup_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .CLK_MHZ(CLK_MHZ),
    .SETTLE_US(SETTLE_US), .REFRESH_COUNT(NREF_B), .T_RP(RP_B),
    .T_RFC(RFC_B), .T_MRD(MRD_B), .MRS_FIRST(MF_B[0])
  ) i_sdram_powerup_seq_alt (
    .clk(clk), .rst(rst), .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_il),
    .cfg_cas_lat(cfg_cl), .cfg_single_write(cfg_sw), .sd_cke(b_cke),
    .sd_dqm(b_dqm), .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas),
    .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr), .init_done(b_done),
    .config_error(b_err)
  );

  // step codes in the plan: 0 NOP, 1 precharge, 2 refresh, 3 mode load
  task automatic build_plan(ref int q[$], output int mrs_at,
                            input int nref, input int rp, input int rfc,
                            input int mrd, input int mf);
    q.delete();
    mrs_at = 0;
    repeat (SETTLE) q.push_back(0);
    q.push_back(1);
    repeat (rp - 1) q.push_back(0);
    if (mf != 0) begin
      mrs_at = q.size();
      q.push_back(3);
      repeat (mrd - 1) q.push_back(0);
    end
    for (int r = 0; r < nref; r++) begin
      q.push_back(2);
      repeat (rfc - 1) q.push_back(0);
    end
    if (mf == 0) begin
      mrs_at = q.size();
      q.push_back(3);
      repeat (mrd - 1) q.push_back(0);
    end
  endtask

  function automatic bit cfg_bad();
    bit cl_ok = (cfg_cl == 3'd2) || (cfg_cl == 3'd3);
    bit bl_ok = (cfg_bl <= 3'd3) || (cfg_bl == 3'd7 && !cfg_il);
    return !(cl_ok && bl_ok);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_mode();
    logic [ADDR_W-1:0] w = '0;
    bit cl_ok = (cfg_cl == 3'd2) || (cfg_cl == 3'd3);
    bit bl_ok = (cfg_bl <= 3'd3) || (cfg_bl == 3'd7 && !cfg_il);
    w[2:0] = bl_ok ? cfg_bl : 3'd0;
    w[3]   = cfg_il;
    w[6:4] = cl_ok ? cfg_cl : 3'd2;
    w[9]   = cfg_sw;
    return w;
  endfunction

  task automatic check_cycle(input string who, input int k, input int q[$],
                             input int mrs_at, input logic cke,
                             input logic [DQM_W-1:0] dqm, input logic [3:0] cmd,
                             input logic [BA_W-1:0] ba,
                             input logic [ADDR_W-1:0] addr,
                             input logic done, input logic err);
    int code;
    logic [3:0] e_cmd;
    logic [ADDR_W-1:0] e_addr;
    logic e_done, e_err;
    string tag;
    if (k < 0) begin
      code = 0; e_done = 1'b0; e_err = 1'b0;
    end else begin
      code   = (k < q.size()) ? q[k] : 0;
      e_done = (k >= q.size());
      e_err  = cfg_bad() && (k >= mrs_at);
    end
    e_addr = '0;
    case (code)
      1: begin e_cmd = 4'b0010; e_addr[10] = 1'b1; tag = "R3"; end
      2: begin e_cmd = 4'b0001; tag = "R4"; end
      3: begin e_cmd = 4'b0000; e_addr = exp_mode(); tag = "R6 R7 R8"; end
      default: begin
        e_cmd = 4'b0111;
        if (k < 0) tag = "R1";
        else if (k < SETTLE) tag = "R2";
        else if (e_done) tag = "R10";
        else tag = "R5";
      end
    endcase
    vectors++;
    if ({cmd, ba, addr} !== {e_cmd, {BA_W{1'b0}}, e_addr}) begin
      miscompares++;
      $display("FAIL %s %s cycle %0d: cmd/ba/addr actual=%b/%b/%h expected=%b/%b/%h",
               tag, who, k, cmd, ba, addr, e_cmd, {BA_W{1'b0}}, e_addr);
    end
    vectors++;
    if ({cke, dqm} !== {1'b1, {DQM_W{1'b1}}}) begin
      miscompares++;
      $display("FAIL R1 %s cycle %0d: cke/dqm actual=%b/%b expected=1/all-ones",
               who, k, cke, dqm);
    end
    vectors++;
    if (done !== e_done) begin
      miscompares++;
      $display("FAIL R10 %s cycle %0d: init_done actual=%b expected=%b",
               who, k, done, e_done);
    end
    vectors++;
    if (err !== e_err) begin
      miscompares++;
      $display("FAIL R9 %s cycle %0d: config_error actual=%b expected=%b",
               who, k, err, e_err);
    end
  endtask

  task automatic check_both(input int k);
    check_cycle("A", k, q_a, mrs_a, a_cke, a_dqm, {a_cs, a_ras, a_cas, a_we},
                a_ba, a_addr, a_done, a_err);
    check_cycle("B", k, q_b, mrs_b, b_cke, b_dqm, {b_cs, b_ras, b_cas, b_we},
                b_ba, b_addr, b_done, b_err);
  endtask

  task automatic run_init(input logic [2:0] bl, input logic il,
                          input logic [2:0] cl, input logic sw);
    int last;
    @(negedge clk);
    rst = 1'b1;
    cfg_bl = bl; cfg_il = il; cfg_cl = cl; cfg_sw = sw;
    build_plan(q_a, mrs_a, NREF_A, RP_A, RFC_A, MRD_A, MF_A);
    build_plan(q_b, mrs_b, NREF_B, RP_B, RFC_B, MRD_B, MF_B);
    // R1: reset state
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check_both(-1);
    end
    rst = 1'b0;
    last = ((q_a.size() > q_b.size()) ? q_a.size() : q_b.size()) + 20;
    for (int k = 0; k < last; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_both(k);
    end
  endtask

  initial begin
    run_init(3'd3, 1'b0, 3'd3, 1'b0); // legal, BL8 sequential, CL3
    run_init(3'd7, 1'b0, 3'd2, 1'b1); // R7 full page sequential, single write
    run_init(3'd7, 1'b1, 3'd3, 1'b0); // R8 full page with interleave -> BL1
    run_init(3'd2, 1'b1, 3'd5, 1'b0); // R8 illegal CL -> 2
    run_init(3'd5, 1'b0, 3'd0, 1'b1); // R8 R9 both fields illegal
    run_init(3'd1, 1'b1, 3'd2, 1'b1); // legal again after errored run
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL R10 watchdog: actual=still running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule